// File: doc/BRIEF.md
# Range Renormalizer with Two-Word Bit Prefetch

This block finishes one step of a binary arithmetic decoder. It takes the 9-bit interval width left after subdivision and the 10-bit code value. It finds how far the width must move left for its top bit to become 1. It then shifts the width by that amount and shifts the same number of fresh stream bits into the low end of the code value. All of this happens combinationally in the cycle the input is presented, so the decoder can produce one bin per cycle.

Stream bits come from two 16-bit holding words. The near word is read from a bit index downward. The far word holds the next word of the stream. When the near word cannot cover the shift, the missing bits are taken from the far word in the same cycle. The far word then becomes the near word, and the far slot is refilled from bitstream memory through a level request and a one-cycle acknowledge. A stall occurs only when such a borrow is needed while the far slot is still empty.

Top module: `renorm_prefetch`

## Requirements
- R1: When `range_in` is nonzero, `shift_cnt` is the number of leading zeros of the 9-bit `range_in` (0 when bit 8 is set). `range_out` equals `range_in` shifted left by `shift_cnt`, so bit 8 of `range_out` is 1.
- R2: `offset_out` equals the low 10 bits of (`offset_in` shifted left by `shift_cnt`) OR the next `shift_cnt` stream bits, with the earliest stream bit in the most significant position. The stream is the sequence of `mem_word` values in acknowledge order, each word read from bit 15 down to bit 0.
- R3: A zero shift consumes no stream bits: `offset_out` equals `offset_in`, and the following accepted input continues from the same stream position.
- R4: When the near word still holds at least `shift_cnt` unread bits, every bit comes from it, `borrow` stays 0, and no memory request is raised by that step.
- R5: When the near word holds fewer unread bits than `shift_cnt`, its remaining bits are used first and the rest come from the top of the far word. `borrow` is 1 in that cycle, the far word becomes the near word with 16 minus the borrowed count bits left, and `mem_req` is 1 from the next cycle.
- R6: `ready` is 0 only when a borrow is needed and the far word is empty. While `ready` is 0 the input is not consumed, and the stream position does not move.
- R7: `mem_req` is 1 exactly while the far word is empty. It stays 1 until `mem_ack`, and it is 0 in the cycle after `mem_ack`. `mem_word` is captured on the acknowledge.
- R8: After reset both words are empty (the near word has 0 unread bits), `mem_req` is 1, and `borrow` is 0.
- R9: The results of an accepted input (`range_out`, `offset_out`, `shift_cnt`, `borrow`) are valid in the same cycle, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An interval width and code value are presented |
| range_in | input | 9 | Interval width after subdivision, nonzero |
| offset_in | input | 10 | Code value after subdivision |
| ready | output | 1 | Presented input is accepted this cycle |
| range_out | output | 9 | Normalized interval width |
| offset_out | output | 10 | Code value with new stream bits appended |
| shift_cnt | output | 4 | Number of positions shifted |
| borrow | output | 1 | Accepted step took bits from the far word |
| mem_req | output | 1 | Far word is empty and a refill is wanted |
| mem_ack | input | 1 | Refill word is on `mem_word` this cycle |
| mem_word | input | 16 | Next 16 stream bits, earliest bit in bit 15 |

## Verification
The normalized width, the new code value, the shift count, `ready` and `borrow` all depend combinationally on the inputs and on registered prefetch state. The bench therefore drives each input just after a falling edge and samples these outputs one nanosecond later, well before the rising edge that commits the step. A refill or a borrow changes only registered state, so `mem_req` is judged one rising edge after the acknowledge or the borrow. The bench also keeps its own count of unread near-word bits and of far-word occupancy, so it knows in which cycle a stall must appear and in which cycle it must clear. The memory responder varies its latency from zero to three cycles, so borrows happen both with a full far word and with an empty one.

// File: rtl/renorm_pkg.sv
// Shared defaults and types for the renormalizer.
// Assumes: one accepted step needs at most RANGE_W-1 stream bits, fewer than one word.
package renorm_pkg;
    localparam int DEF_RANGE_W = 9;
    localparam int DEF_OFF_W   = 10;
    localparam int DEF_WORD_W  = 16;

    // Where the appended bits of one step come from
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_NEAR  = 2'd1,
        SRC_SPLIT = 2'd2
    } bit_src_e;
endpackage

// File: rtl/renorm_shift_det.sv
// Finds the left shift that puts a 1 in the top bit of the interval width.
// Assumes: the width is nonzero when used; a zero width yields a shift of 0.
module renorm_shift_det #(
    parameter int RANGE_W = renorm_pkg::DEF_RANGE_W,
    parameter int SH_W    = $clog2(RANGE_W)
) (
    input  logic [RANGE_W-1:0] width_i,
    output logic [SH_W-1:0]    shift_o
);
    // Priority search from the top bit for the first set position
    always_comb begin
        logic found;
        found   = 1'b0;
        shift_o = '0;
        for (int i = RANGE_W - 1; i >= 0; i--) begin
            if (!found && width_i[i]) begin
                shift_o = SH_W'(RANGE_W - 1 - i);
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/renorm_bit_window.sv
// Picks the next 'need' stream bits from the near word, borrowing from the far word
// when the near word runs short, and gives the near-word index after the step.
// Assumes: need < WORD_W, BITS_W <= WORD_W, near index <= WORD_W.
module renorm_bit_window
    import renorm_pkg::*;
#(
    parameter int WORD_W = renorm_pkg::DEF_WORD_W,
    parameter int BITS_W = renorm_pkg::DEF_RANGE_W,
    parameter int IDX_W  = $clog2(WORD_W + 1),
    parameter int SH_W   = 4
) (
    input  logic [WORD_W-1:0] near_i,
    input  logic [IDX_W-1:0]  near_idx_i,
    input  logic [WORD_W-1:0] far_i,
    input  logic [SH_W-1:0]   need_i,
    output logic [BITS_W-1:0] bits_o,
    output logic              borrow_o,
    output logic [IDX_W-1:0]  idx_next_o
);
    localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(WORD_W);

    bit_src_e          src;
    logic [IDX_W-1:0]  need;
    logic [IDX_W-1:0]  from_far;
    logic [WORD_W-1:0] near_rem;
    logic [WORD_W-1:0] need_mask;
    logic [WORD_W-1:0] wide_bits;

    // Classify the step: nothing to take, near word only, or split across both words
    always_comb begin
        need = IDX_W'(need_i);
        if (need == '0)              src = SRC_NONE;
        else if (need <= near_idx_i) src = SRC_NEAR;
        else                         src = SRC_SPLIT;
    end

    // Unread near-word bits and a mask of the requested count
    always_comb begin
        near_rem  = near_i & ~({WORD_W{1'b1}} << near_idx_i);
        need_mask = ~({WORD_W{1'b1}} << need);
        from_far  = need - near_idx_i;
    end

    // Gather the bits and the index that follows this step
    always_comb begin
        unique case (src)
            SRC_NEAR: begin
                wide_bits  = (near_rem >> (near_idx_i - need)) & need_mask;
                idx_next_o = near_idx_i - need;
            end
            SRC_SPLIT: begin
                wide_bits  = (near_rem << from_far) | (far_i >> (FULL_IDX - from_far));
                idx_next_o = FULL_IDX - from_far;
            end
            default: begin
                wide_bits  = '0;
                idx_next_o = near_idx_i;
            end
        endcase
        bits_o   = wide_bits[BITS_W-1:0];
        borrow_o = (src == SRC_SPLIT);
    end
endmodule

// File: rtl/renorm_prefetch_regs.sv
// Holds the near word, its unread-bit index, and the far word with its fill flag.
// Runs the refill handshake: a level request while the far word is empty, a one-cycle ack.
// Assumes: a borrow is only committed while the far word is full.
module renorm_prefetch_regs #(
    parameter int WORD_W = renorm_pkg::DEF_WORD_W,
    parameter int IDX_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              borrow_i,
    input  logic [IDX_W-1:0]  idx_next_i,
    input  logic              ack_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] near_o,
    output logic [IDX_W-1:0]  near_idx_o,
    output logic [WORD_W-1:0] far_o,
    output logic              far_full_o,
    output logic              req_o
);
    // Advance the read position, promote the far word on a borrow, and capture refills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            near_o     <= '0;
            near_idx_o <= '0;
            far_o      <= '0;
            far_full_o <= 1'b0;
        end else begin
            if (step_i) begin
                near_idx_o <= idx_next_i;
                if (borrow_i) begin
                    near_o     <= far_o;
                    far_full_o <= 1'b0;
                end
            end
            if (ack_i && !far_full_o) begin
                far_o      <= word_i;
                far_full_o <= 1'b1;
            end
        end
    end

    // Ask memory for a word whenever the far slot is empty
    always_comb req_o = !far_full_o;
endmodule

// File: rtl/renorm_prefetch.sv
// Renormalizes the interval width and refills the code value from a two-word prefetch.
// The result is combinational in the cycle of acceptance; only prefetch state is registered.
// Assumes: range_in is nonzero whenever in_valid is high.
module renorm_prefetch #(
    parameter int RANGE_W = renorm_pkg::DEF_RANGE_W,
    parameter int OFF_W   = renorm_pkg::DEF_OFF_W,
    parameter int WORD_W  = renorm_pkg::DEF_WORD_W,
    parameter int SH_W    = $clog2(RANGE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [RANGE_W-1:0] range_in,
    input  logic [OFF_W-1:0]   offset_in,
    output logic               ready,
    output logic [RANGE_W-1:0] range_out,
    output logic [OFF_W-1:0]   offset_out,
    output logic [SH_W-1:0]    shift_cnt,
    output logic               borrow,
    output logic               mem_req,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_word
);
    localparam int IDX_W = $clog2(WORD_W + 1);

    logic [SH_W-1:0]    shift;
    logic [RANGE_W-1:0] new_bits;
    logic               need_borrow;
    logic [IDX_W-1:0]   idx_next;
    logic [WORD_W-1:0]  near_word;
    logic [IDX_W-1:0]   near_idx;
    logic [WORD_W-1:0]  far_word;
    logic               far_full;
    logic               step;

    renorm_shift_det #(.RANGE_W(RANGE_W), .SH_W(SH_W)) u_shift (
        .width_i (range_in),
        .shift_o (shift)
    );

    renorm_bit_window #(.WORD_W(WORD_W), .BITS_W(RANGE_W), .IDX_W(IDX_W), .SH_W(SH_W)) u_window (
        .near_i     (near_word),
        .near_idx_i (near_idx),
        .far_i      (far_word),
        .need_i     (shift),
        .bits_o     (new_bits),
        .borrow_o   (need_borrow),
        .idx_next_o (idx_next)
    );

    renorm_prefetch_regs #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .borrow_i   (need_borrow),
        .idx_next_i (idx_next),
        .ack_i      (mem_ack),
        .word_i     (mem_word),
        .near_o     (near_word),
        .near_idx_o (near_idx),
        .far_o      (far_word),
        .far_full_o (far_full),
        .req_o      (mem_req)
    );

    // Accept unless a borrow is needed from an empty far word
    always_comb begin
        ready = !(need_borrow && !far_full);
        step  = in_valid && ready;
    end

    // Shift the width and the code value, appending the gathered stream bits
    always_comb begin
        shift_cnt  = shift;
        range_out  = range_in << shift;
        offset_out = (offset_in << shift) | OFF_W'(new_bits);
        borrow     = step && need_borrow;
    end
endmodule

// File: rtl/renorm_prefetch_chk.sv
// Temporal checks on the renormalizer ports, bound into every instance.
// Assumes: the same parameter values as the bound instance.
module renorm_prefetch_chk #(
    parameter int RANGE_W = 9,
    parameter int OFF_W   = 10,
    parameter int WORD_W  = 16,
    parameter int SH_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [RANGE_W-1:0] range_in,
    input logic [OFF_W-1:0]   offset_in,
    input logic               ready,
    input logic [RANGE_W-1:0] range_out,
    input logic [OFF_W-1:0]   offset_out,
    input logic [SH_W-1:0]    shift_cnt,
    input logic               borrow,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [WORD_W-1:0]  mem_word
);
    // R1
    msb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready && range_in != '0) |-> range_out[RANGE_W-1]);

    // R3
    zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready && range_in[RANGE_W-1]) |-> (shift_cnt == '0 && offset_out == offset_in && !borrow));

    // R4
    no_borrow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready && !borrow && !mem_req) |=> !mem_req);

    // R5
    borrow_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |=> mem_req);

    // R6
    stall_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ready) |-> (mem_req && !borrow));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |=> !mem_req);
endmodule

bind renorm_prefetch renorm_prefetch_chk #(
    .RANGE_W(RANGE_W), .OFF_W(OFF_W), .WORD_W(WORD_W), .SH_W(SH_W)
) u_chk (.*);

// File: tb/renorm_prefetch_tb.sv
module renorm_prefetch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [8:0] range_in = '0;
    logic [9:0] offset_in = '0;
    logic       ready;
    logic [8:0] range_out;
    logic [9:0] offset_out;
    logic [3:0] shift_cnt;
    logic       borrow;
    logic       mem_req;
    logic       mem_ack = 1'b0;
    logic [15:0] mem_word = '0;

    int checks = 0;
    int fails  = 0;
    int stream_pos = 0;   // next stream bit to be consumed
    int near_left = 0;    // model: unread near-word bits
    bit far_full = 1'b0;  // model: far word occupancy
    int words_sent = 0;
    int wait_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    renorm_prefetch u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .range_in(range_in),
        .offset_in(offset_in), .ready(ready), .range_out(range_out),
        .offset_out(offset_out), .shift_cnt(shift_cnt), .borrow(borrow),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_word(mem_word)
    );

    function automatic logic [15:0] word_of(int j);
        return 16'((j * 40503) ^ (j << 5) ^ 16'h3C96);
    endfunction

    function automatic bit stream_bit(int p);
        logic [15:0] w;
        w = word_of(p / 16);
        return w[15 - (p % 16)];
    endfunction

    function automatic int lead_zeros(int r);
        int n;
        n = 0;
        for (int i = 8; i >= 0; i--) begin
            if (r[i]) return n;
            n++;
        end
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: latency of 0..3 cycles, one-cycle acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (rst_n && mem_req) begin
                if (wait_cnt >= (words_sent % 4)) begin
                    mem_word = word_of(words_sent);
                    mem_ack  = 1'b1;
                    words_sent++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // One step: drive after a falling edge, judge outputs 1 ns later, wait out stalls
    task automatic step(input int r, input int off);
        int n;
        int bits;
        int exp_off;
        bit exp_ready;
        bit exp_borrow;
        bit accepted;
        n = lead_zeros(r);
        accepted = 1'b0;
        @(negedge clk);
        in_valid  = 1'b1;
        range_in  = 9'(r);
        offset_in = 10'(off);
        while (!accepted) begin
            #1;
            exp_borrow = (n > near_left);
            exp_ready  = !(exp_borrow && !far_full);
            check(mem_req == !far_full, "R7 mem_req", int'(mem_req), int'(!far_full));
            check(ready == exp_ready, "R6 ready", int'(ready), int'(exp_ready));
            if (ready) begin
                bits = 0;
                for (int i = 0; i < n; i++) bits = (bits << 1) | int'(stream_bit(stream_pos + i));
                exp_off = ((off << n) | bits) & 1023;
                check(int'(shift_cnt) == n, "R1 shift", int'(shift_cnt), n);
                check(int'(range_out) == ((r << n) & 511), "R1 range", int'(range_out), (r << n) & 511);
                check(int'(offset_out) == exp_off, "R2 R9 offset", int'(offset_out), exp_off);
                if (n == 0) check(offset_out == offset_in, "R3 zero shift", int'(offset_out), off);
                check(borrow == exp_borrow, exp_borrow ? "R5 borrow" : "R4 no borrow", int'(borrow), int'(exp_borrow));
                stream_pos += n;
                if (exp_borrow) begin
                    near_left = 16 - (n - near_left);
                    far_full  = 1'b0;
                end else begin
                    near_left -= n;
                end
                accepted = 1'b1;
            end else begin
                check(borrow == 1'b0, "R6 no borrow in stall", int'(borrow), 0);
            end
            if (mem_ack) far_full = 1'b1;
            if (!accepted) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(mem_req == 1'b1, "R8 req after reset", int'(mem_req), 1);
        check(borrow == 1'b0, "R8 borrow after reset", int'(borrow), 0);
        // First step needs 8 bits from an empty near word: must stall until a refill (R8, R6)
        step(1, 10'h155);
        // Every nonzero width once
        for (int r = 1; r < 512; r++) step(r, (r * 7) & 1023);
        // Maximum shifts back to back to force frequent borrows
        for (int k = 0; k < 60; k++) step(1 + (k % 2), (k * 13) & 1023);
        // Mixed pattern of small and zero shifts
        for (int k = 0; k < 200; k++) step((k % 3 == 0) ? 300 : ((k % 3 == 1) ? 64 + k : 5), k & 1023);
        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule